// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Register Block

This block sits beside a real-time clock timebase and owns everything that turns the passing of seconds into interrupts. The timebase supplies a 32-bit seconds count and a one-cycle pulse at each second boundary. The block keeps a 32-bit alarm compare value and two sticky event flags, one per second boundary and one for an alarm match. It drives one interrupt line for each of the two events.

Software reaches the block through a plain write strobe with an address and data. Reads are combinational from the same address. Interrupt sources are switched on through one write-one-to-set register and switched off through another write-one-to-clear register. The resulting per-source enable state can only be read, at its own offset. Event flags are cleared by writing a one to them.

Top module: `rtc_alarm_intc`

## Requirements
- R1: After reset the event flags read 0, the enable state reads 0, the alarm value reads 0, and both interrupt outputs are low.
- R2: The alarm value is read and written as a full 32-bit word at byte offset 0x18.
- R3: A cycle with `secPulse` high sets event flag bit 0 (seconds). The flag reads back at offset 0x20 from the cycle after the pulse.
- R4: A `secPulse` cycle in which `curTime` equals the alarm value sets event flag bit 1 (alarm). Further pulses while the two stay equal do not set it again. The match is re-armed by a pulse at which they differ, or by any write to the alarm value.
- R5: A write to offset 0x20 clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R6: If a flag is set by an event in the same cycle that a write of 1 would clear it, the flag ends up set.
- R7: A write to offset 0x28 turns on each source whose data bit is 1 (bit 0 seconds, bit 1 alarm). A write to offset 0x2C turns off each source whose data bit is 1. Zero bits in either write change nothing.
- R8: Offset 0x24 reads the enable state, with seconds at bit 0 and alarm at bit 1. Writes to 0x24 are ignored.
- R9: `secIrq` equals flag bit 0 AND the seconds enable. `alarmIrq` equals flag bit 1 AND the alarm enable. Flags still set while their source is disabled.
- R10: Reads of 0x28, 0x2C and any unmapped offset return zero. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| curTime | input | 32 | Current seconds count from the timebase |
| secPulse | input | 1 | One-cycle pulse marking a second boundary |
| secIrq | output | 1 | Seconds interrupt |
| alarmIrq | output | 1 | Alarm interrupt |

## Verification
Every flag, enable and alarm bit is visible through `rdData` in the cycle after it changes, and the flags and enables also appear on the interrupt lines in that cycle. A corrupted bit therefore shows up at the next read of its offset or the next interrupt comparison, one clock after the fault. The hidden re-arm state is the exception. A wrong value there only shows when a later pulse coincides with the alarm value, as a missing or repeated alarm flag. The stimulus therefore holds `curTime` equal to the alarm across several pulses and rewrites the alarm while they are equal.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_SRC   = 2;
  localparam int SRC_SEC   = 0;
  localparam int SRC_ALARM = 1;

  typedef struct packed {
    logic               wrAlarm;
    logic [NUM_SRC-1:0] setSts;
    logic [NUM_SRC-1:0] clrSts;
    logic [NUM_SRC-1:0] setEn;
    logic [NUM_SRC-1:0] clrEn;
  } ctlStrobes_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFF_ALARM = 'h18,
  parameter int OFF_STS   = 'h20,
  parameter int OFF_EN    = 'h28,
  parameter int OFF_DIS   = 'h2C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic               secPulse,
  input  logic               matchNow,
  output ctlStrobes_t        strb
);
  logic armedQ;
  logic alarmEvent;
  logic hitAlarm, hitSts, hitEn, hitDis;

  assign hitAlarm   = wrEn && (addr == ADDR_W'(OFF_ALARM));
  assign hitSts     = wrEn && (addr == ADDR_W'(OFF_STS));
  assign hitEn      = wrEn && (addr == ADDR_W'(OFF_EN));
  assign hitDis     = wrEn && (addr == ADDR_W'(OFF_DIS));
  assign alarmEvent = secPulse && matchNow && armedQ;

  always_comb begin
    strb                    = '0;
    strb.wrAlarm            = hitAlarm;
    strb.setSts[SRC_SEC]    = secPulse;
    strb.setSts[SRC_ALARM]  = alarmEvent;
    strb.clrSts             = hitSts ? wrBits : '0;
    strb.setEn              = hitEn  ? wrBits : '0;
    strb.clrEn              = hitDis ? wrBits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            armedQ <= 1'b1;
    else if (hitAlarm)    armedQ <= 1'b1;
    else if (alarmEvent)  armedQ <= 1'b0;
    else if (!matchNow)   armedQ <= 1'b1;
  end
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TIME_W    = 32,
  parameter int OFF_ALARM = 'h18,
  parameter int OFF_STS   = 'h20,
  parameter int OFF_MASK  = 'h24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [TIME_W-1:0]  curTime,
  output logic               matchNow,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] stsVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] irqVec
);
  logic [TIME_W-1:0] alarmQ;

  assign matchNow = (curTime == alarmQ);

  always_ff @(posedge clk) begin
    if (!rstN)             alarmQ <= '0;
    else if (strb.wrAlarm) alarmQ <= wrData[TIME_W-1:0];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN)                stsVec[s] <= 1'b0;
      else if (strb.setSts[s])  stsVec[s] <= 1'b1;
      else if (strb.clrSts[s])  stsVec[s] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                enVec[s] <= 1'b0;
      else if (strb.setEn[s])   enVec[s] <= 1'b1;
      else if (strb.clrEn[s])   enVec[s] <= 1'b0;
    end
    assign irqVec[s] = stsVec[s] & enVec[s];
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFF_ALARM))     rdData = DATA_W'(alarmQ);
    else if (addr == ADDR_W'(OFF_STS))  rdData = DATA_W'(stsVec);
    else if (addr == ADDR_W'(OFF_MASK)) rdData = DATA_W'(enVec);
  end
endmodule

// File: rtl/rtc_alarm_intc.sv
module rtc_alarm_intc
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TIME_W    = 32,
  parameter int OFF_ALARM = 'h18,
  parameter int OFF_STS   = 'h20,
  parameter int OFF_MASK  = 'h24,
  parameter int OFF_EN    = 'h28,
  parameter int OFF_DIS   = 'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [TIME_W-1:0] curTime,
  input  logic              secPulse,
  output logic              secIrq,
  output logic              alarmIrq
);
  ctlStrobes_t        strb;
  logic               matchNow;
  logic [NUM_SRC-1:0] stsVec, enVec, irqVec;

  rtc_alarm_ctrl #(
    .ADDR_W(ADDR_W), .OFF_ALARM(OFF_ALARM), .OFF_STS(OFF_STS),
    .OFF_EN(OFF_EN), .OFF_DIS(OFF_DIS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrBits(wrData[NUM_SRC-1:0]), .secPulse(secPulse),
    .matchNow(matchNow), .strb(strb)
  );

  rtc_alarm_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W),
    .OFF_ALARM(OFF_ALARM), .OFF_STS(OFF_STS), .OFF_MASK(OFF_MASK)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .curTime(curTime), .matchNow(matchNow), .rdData(rdData),
    .stsVec(stsVec), .enVec(enVec), .irqVec(irqVec)
  );

  assign secIrq   = irqVec[SRC_SEC];
  assign alarmIrq = irqVec[SRC_ALARM];
endmodule

// File: rtl/rtc_alarm_intc_chk.sv
module rtc_alarm_intc_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int OFF_STS = 'h20,
  parameter int OFF_EN  = 'h28,
  parameter int OFF_DIS = 'h2C
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              secPulse,
  input logic              secIrq,
  input logic              alarmIrq,
  input logic [1:0]        stsVec,
  input logic [1:0]        enVec
);
  logic wrSts, wrEnReg, wrDis;
  assign wrSts   = wrEn && (addr == ADDR_W'(OFF_STS));
  assign wrEnReg = wrEn && (addr == ADDR_W'(OFF_EN));
  assign wrDis   = wrEn && (addr == ADDR_W'(OFF_DIS));

  assert_sec_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> stsVec[0]);

  assert_alarm_needs_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsVec[1]) |-> $past(secPulse));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrSts && wrData[0] && !secPulse) |=> !stsVec[0]);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stsVec[0] && !(wrSts && wrData[0])) |=> stsVec[0]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && wrSts && wrData[0]) |=> stsVec[0]);

  assert_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnReg && wrData[1]) |=> enVec[1]);

  assert_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrDis && wrData[1]) |=> !enVec[1]);

  assert_gate_sec_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enVec[0] |-> !secIrq);

  assert_gate_alarm_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stsVec[1] |-> !alarmIrq);
endmodule

bind rtc_alarm_intc rtc_alarm_intc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_STS(OFF_STS),
  .OFF_EN(OFF_EN), .OFF_DIS(OFF_DIS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .secPulse(secPulse), .secIrq(secIrq), .alarmIrq(alarmIrq),
  .stsVec(stsVec), .enVec(enVec)
);

// File: tb/rtc_alarm_intc_tb.sv
module rtc_alarm_intc_tb_top;
  localparam logic [7:0] A_ALARM = 8'h18, A_STS = 8'h20, A_MASK = 8'h24,
                         A_EN = 8'h28, A_DIS = 8'h2C;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, secPulse = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0, curTime = '0, rdData;
  logic secIrq, alarmIrq;

  int vecs = 0, errs = 0;
  logic [1:0]  expSts = '0, expEn = '0;
  logic [31:0] expAlarm = '0;
  logic        expArmed = 1'b1;
  logic [31:0] tNow = 32'd100;

  always #10 clk = ~clk;

  rtc_alarm_intc dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .curTime(curTime), .secPulse(secPulse),
    .secIrq(secIrq), .alarmIrq(alarmIrq)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      A_ALARM: return expAlarm;
      A_STS:   return {30'd0, expSts};
      A_MASK:  return {30'd0, expEn};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive, check the read of addr, advance the model, check interrupts.
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic p, input logic [31:0] t, input string req);
    logic match, ev;
    logic [1:0] nSts, nEn;
    logic [31:0] nAl;
    logic nArm;
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; secPulse = p; curTime = t;
    #2;
    check({req, " read R2/R8/R10"}, rdData, expRead(a));
    match = (t == expAlarm);
    ev    = p && match && expArmed;
    nSts  = expSts;
    if (w && a == A_STS) nSts = nSts & ~d[1:0];
    if (p)  nSts[0] = 1'b1;
    if (ev) nSts[1] = 1'b1;
    nEn = expEn;
    if (w && a == A_EN)  nEn = nEn | d[1:0];
    if (w && a == A_DIS) nEn = nEn & ~d[1:0];
    nAl  = (w && a == A_ALARM) ? d : expAlarm;
    nArm = (w && a == A_ALARM) ? 1'b1 : ev ? 1'b0 : !match ? 1'b1 : expArmed;
    @(posedge clk);
    #1;
    expSts = nSts; expEn = nEn; expAlarm = nAl; expArmed = nArm;
    check({req, " secIrq R9"},   {31'd0, secIrq},   {31'd0, expSts[0] & expEn[0]});
    check({req, " alarmIrq R9"}, {31'd0, alarmIrq}, {31'd0, expSts[1] & expEn[1]});
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(1'b0, a, 32'd0, 1'b0, tNow, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    step(1'b1, a, d, 1'b0, tNow, req);
  endtask

  task automatic tick(input string req);
    tNow++;
    step(1'b0, A_STS, 32'd0, 1'b1, tNow, req);
  endtask

  initial begin : watchdog
    #3_000_000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset values
    rd(A_STS, "R1"); rd(A_MASK, "R1"); rd(A_ALARM, "R1");
    check("R1 irqs", {30'd0, secIrq, alarmIrq}, 32'd0);
    // R2: full-width alarm, R10 unmapped/write-only reads
    wr(A_ALARM, 32'hFFFF_FFFF, "R2"); rd(A_ALARM, "R2");
    wr(A_ALARM, 32'hA5A5_0001, "R2"); rd(A_ALARM, "R2");
    wr(8'h30, 32'hFFFF_FFFF, "R10"); rd(8'h30, "R10"); rd(A_EN, "R10"); rd(A_DIS, "R10");
    rd(A_ALARM, "R10");
    // R8: writes to mask ignored; R7 enable/disable
    wr(A_MASK, 32'h3, "R8"); rd(A_MASK, "R8");
    wr(A_EN, 32'h2, "R7"); rd(A_MASK, "R7");
    wr(A_EN, 32'h0, "R7"); wr(A_DIS, 32'h0, "R7"); rd(A_MASK, "R7");
    wr(A_EN, 32'h1, "R7"); wr(A_DIS, 32'h2, "R7"); rd(A_MASK, "R7");
    // R3/R9 seconds flag and gating
    wr(A_DIS, 32'h3, "R9"); tick("R3"); rd(A_STS, "R9 disabled still sets");
    wr(A_EN, 32'h1, "R9"); rd(A_STS, "R9");
    // R5 clear semantics
    wr(A_STS, 32'h0, "R5"); rd(A_STS, "R5");
    wr(A_STS, 32'h1, "R5"); rd(A_STS, "R5");
    // R6 set wins over clear
    tNow++; step(1'b1, A_STS, 32'h1, 1'b1, tNow, "R6"); rd(A_STS, "R6");
    // R4 alarm once while equal, re-arm by rewrite and by mismatch
    wr(A_EN, 32'h2, "R4");
    wr(A_ALARM, tNow + 2, "R4"); tick("R4"); tick("R4"); rd(A_STS, "R4");
    wr(A_STS, 32'h3, "R4");
    step(1'b0, A_STS, 32'd0, 1'b1, tNow, "R4 hold equal");
    step(1'b0, A_STS, 32'd0, 1'b1, tNow, "R4 hold equal");
    wr(A_ALARM, tNow, "R4 rewrite");
    step(1'b0, A_STS, 32'd0, 1'b1, tNow, "R4 rearmed");
    wr(A_STS, 32'h2, "R4");
    step(1'b0, A_STS, 32'd0, 1'b1, tNow + 5, "R4 mismatch");
    step(1'b0, A_STS, 32'd0, 1'b1, tNow, "R4 rearm by mismatch");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      logic [7:0] a;
      sel = $urandom_range(0, 9);
      case ($urandom_range(0, 6))
        0: a = A_ALARM; 1: a = A_STS; 2: a = A_MASK; 3: a = A_EN;
        4: a = A_DIS; 5: a = 8'($urandom_range(0, 255)); default: a = A_STS;
      endcase
      if (sel < 3) begin
        logic [31:0] d;
        d = (a == A_ALARM) ? tNow + 32'($urandom_range(0, 3)) : 32'($urandom_range(0, 3));
        step(1'b1, a, d, $urandom_range(0, 3) == 0, tNow, "R5/R7 random");
      end else if (sel < 6) begin
        if ($urandom_range(0, 1) == 1) tNow++;
        step(1'b0, a, 32'd0, 1'b1, tNow, "R3/R4 random");
      end else begin
        step(1'b0, a, 32'd0, 1'b0, tNow, "R8 random");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule